// File: doc/BRIEF.md
# Overcurrent Response Mode Controller

This block sits behind the analog current-limit comparator of a protected high-side load switch. It decides what the power stage does once the comparator reports that the output current is being clamped. It drives the gate enable and raises an overcurrent request for the fault reporter. A 2-bit strap selects one of three policies:

- **Hold:** keep conducting while limited.
- **Latch-off:** cut off after a fixed delay plus a programmable delay, then wait for the command to be toggled.
- **Auto-retry:** hiccup the output with a short on-window and a long off-window for as long as limiting is seen.

All durations are counted in ticks of a one-microsecond enable. Every duration is a parameter except the extra latch-off delay, which arrives on a port as a tick count. That count replaces the timing capacitor of an analog implementation.

A fast-trip input cuts the gate on the next clock edge, without waiting for the limit loop to settle. A thermal shutdown flag can also remove the gate in any policy. A falling command always abandons any pending delay or retry cycle and returns the controller to idle. The overcurrent request is deglitched, and it is held for a while after the command drops. A PWM-style command therefore cannot hide a fault that persists.

Top module: `ocp_mode_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `gate_en` and `oc_fault` are both low.
- R2: With the command high and no limiting, fast trip or thermal flag, `gate_en` is high one clock after the command is first sampled high. A low command forces `gate_en` low on the next clock and abandons any latch-off delay or retry window. A new high command then turns the gate on after one clock, with no wait.
- R3: In hold policy (`mode_sel` 00, and also 11), `gate_en` stays high for as long as limiting lasts. In every policy, a high `therm_sd` makes `gate_en` low on the next clock. `gate_en` returns one clock after `therm_sd` falls, provided the command and the policy still allow conduction.
- R4: In latch-off policy (`mode_sel` 01), limiting starts the delay at the clock where `ilim_act` is first sampled. If limiting continues for LATCH_FIXED + `latch_extra` ticks after that clock, `gate_en` falls at the next clock. If limiting stops before the delay runs out, the delay restarts from zero at the next limiting episode.
- R5: Once latched off, the gate stays off while the command stays high, whether or not limiting remains. It turns on again one clock after the command has gone low and then high.
- R6: In auto-retry policy (`mode_sel` 10), limiting opens an on-window of RETRY_ON ticks. If limiting was seen during the window, an off-window of RETRY_OFF ticks follows with the gate low, and then a new on-window starts. An on-window that ends with no limiting seen returns the controller to normal conduction and clears `oc_fault` at the same clock.
- R7: `oc_fault` rises at the clock that completes DEG_RUN consecutive ticks of limiting while the gate is on and the command is high. Fewer ticks, or a break in limiting, leave it low.
- R8: If limiting is present from the command's rising edge, the deglitch length is DEG_EDGE ticks instead of DEG_RUN. This applies until the first cycle in which the gate is on with no limiting.
- R9: A high `fast_trip` makes `gate_en` low on the next clock. If the gate was on with the command high, it also sets `oc_fault`. Under hold and latch-off policy the switch then stays latched off (as in R5). Under auto-retry policy an off-window starts.
- R10: `oc_fault` clears at the clock that completes FAULT_HOLD ticks of the command being low. If the command returns high before then, the count restarts, and no fault is ever raised while the command is low.
- R11: Under hold policy, `oc_fault` clears at the first clock where the gate is on, the command is high and limiting is absent.
- R12: Under latch-off policy, `oc_fault` clears only through the command-low rule of R10. The end of limiting does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle timing enable, nominally once per microsecond |
| cmd_on | input | 1 | Switch command, high requests conduction |
| ilim_act | input | 1 | Analog current-limit loop is clamping |
| fast_trip | input | 1 | Hard-short comparator, acts within one clock |
| therm_sd | input | 1 | Thermal shutdown active |
| mode_sel | input | 2 | Policy strap: 00/11 hold, 01 latch-off, 10 auto-retry |
| latch_extra | input | DLY_W | Extra latch-off delay in ticks |
| gate_en | output | 1 | Gate drive enable for the power stage |
| oc_fault | output | 1 | Overcurrent request to the fault reporter |

## Verification
The embedded properties check the following on every cycle:
- the gate falls one clock after a fast trip, a thermal flag or a low command;
- a latched-off switch stays dark while the command is held;
- hold policy keeps conducting through limiting;
- a fault never appears without limiting or a trip, and never while the command is low;
- a latch-off fault stays set while the command stays high.

Exact window lengths can only be shown by the bench's timed scenarios. These cover the latch-off delay with a random extra count, the retry on/off cadence and clean-window recovery, the longer deglitch from a rising edge, and the restart of the hold timer. Random pulses with random tick density exercise the deglitch threshold against a tick count kept in the bench.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    POL_HOLD  = 2'b00,
    POL_LATCH = 2'b01,
    POL_RETRY = 2'b10,
    POL_HOLD2 = 2'b11
  } ocp_pol_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ON        = 3'd1,
    ST_LIMIT     = 3'd2,
    ST_LATCHED   = 3'd3,
    ST_RETRY_ON  = 3'd4,
    ST_RETRY_OFF = 3'd5
  } ocp_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..n
  function automatic int cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic logic pol_hold(input logic [1:0] m);
    return (m == POL_HOLD) || (m == POL_HOLD2);
  endfunction

  function automatic logic pol_latch(input logic [1:0] m);
    return m == POL_LATCH;
  endfunction

  function automatic logic pol_retry(input logic [1:0] m);
    return m == POL_RETRY;
  endfunction

  // states in which the power stage may conduct
  function automatic logic drives_gate(input ocp_st_e s);
    return (s == ST_ON) || (s == ST_LIMIT) || (s == ST_RETRY_ON);
  endfunction

  // states whose dwell is measured by the policy timer
  function automatic logic timed_state(input ocp_st_e s, input logic [1:0] m);
    return (s == ST_LIMIT && pol_latch(m)) || (s == ST_RETRY_ON) || (s == ST_RETRY_OFF);
  endfunction

endpackage

// File: rtl/ocp_tick_counter.sv
module ocp_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] target,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic [W:0]   nxt;

  assign nxt = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  // hit marks the advancing tick that completes the target count
  assign hit = adv && (nxt >= {1'b0, target});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (adv && cnt != '1)   cnt <= nxt[W-1:0];
  end

  p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hit || nxt == {{W{1'b0}}, 1'b1});

endmodule

// File: rtl/ocp_policy_fsm.sv
module ocp_policy_fsm
  import ocp_pkg::*;
#(
  parameter int unsigned LATCH_FIXED = 400,
  parameter int unsigned RETRY_ON    = 40000,
  parameter int unsigned RETRY_OFF   = 1000000,
  parameter int unsigned DLY_W       = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_on,
  input  logic             ilim,
  input  logic             fast_trip,
  input  logic             therm,
  input  logic [1:0]       mode,
  input  logic [DLY_W-1:0] extra,
  output logic             gate_en,
  output logic             retry_clean
);
  localparam int unsigned LATCH_MAX = LATCH_FIXED + (2 ** DLY_W) - 1;
  localparam int TMR_W = cnt_width(umax(umax(RETRY_ON, RETRY_OFF), LATCH_MAX));

  ocp_st_e          st, st_n;
  logic             seen, seen_now;
  logic [TMR_W-1:0] tgt;
  logic             tmr_hit, tmr_clr, tmr_adv;
  ocp_st_e          trip_dest;

  function automatic logic [TMR_W-1:0] latch_span(input logic [DLY_W-1:0] x);
    return TMR_W'(LATCH_FIXED) + TMR_W'(x);
  endfunction

  assign seen_now  = seen | ilim;
  assign trip_dest = pol_retry(mode) ? ST_RETRY_OFF : ST_LATCHED;

  always_comb begin
    case (st)
      ST_LIMIT:     tgt = latch_span(extra);
      ST_RETRY_ON:  tgt = TMR_W'(RETRY_ON);
      ST_RETRY_OFF: tgt = TMR_W'(RETRY_OFF);
      default:      tgt = '0;
    endcase
  end

  assign tmr_adv = tick && timed_state(st, mode);
  assign tmr_clr = (st_n != st);

  ocp_tick_counter #(.W(TMR_W)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .adv    (tmr_adv),
    .target (tgt),
    .hit    (tmr_hit)
  );

  always_comb begin
    st_n = st;
    if (!cmd_on) begin
      st_n = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (!fast_trip) st_n = ST_ON;
        ST_ON: begin
          if (fast_trip)  st_n = trip_dest;
          else if (ilim)  st_n = pol_retry(mode) ? ST_RETRY_ON : ST_LIMIT;
        end
        ST_LIMIT: begin
          if (fast_trip)                        st_n = trip_dest;
          else if (!ilim)                       st_n = ST_ON;
          else if (pol_latch(mode) && tmr_hit)  st_n = ST_LATCHED;
        end
        ST_LATCHED: st_n = ST_LATCHED;
        ST_RETRY_ON: begin
          if (fast_trip)    st_n = ST_RETRY_OFF;
          else if (tmr_hit) st_n = seen_now ? ST_RETRY_OFF : ST_ON;
        end
        ST_RETRY_OFF: if (tmr_hit) st_n = ST_RETRY_ON;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  assign retry_clean = cmd_on && (st == ST_RETRY_ON) && !fast_trip && tmr_hit && !seen_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      seen    <= 1'b0;
      gate_en <= 1'b0;
    end else begin
      st      <= st_n;
      gate_en <= drives_gate(st_n) && !therm && !fast_trip;
      if (st_n == ST_RETRY_ON && st == ST_ON)       seen <= 1'b1;
      else if (st_n == ST_RETRY_ON && st != ST_RETRY_ON) seen <= 1'b0;
      else if (st == ST_RETRY_ON)                   seen <= seen_now;
    end
  end

  p_fast_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trip |=> !gate_en);

  p_cmd_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |=> (st == ST_IDLE && !gate_en));

  p_therm_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    therm |=> !gate_en);

  p_hold_conducts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_hold(mode) && st == ST_LIMIT && ilim && cmd_on && !therm && !fast_trip) |=> gate_en);

  p_latched_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LATCHED && cmd_on) |=> (st == ST_LATCHED && !gate_en));

endmodule

// File: rtl/ocp_fault_flag.sv
module ocp_fault_flag
  import ocp_pkg::*;
#(
  parameter int unsigned DEG_RUN    = 130,
  parameter int unsigned DEG_EDGE   = 400,
  parameter int unsigned FAULT_HOLD = 8500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_on,
  input  logic       cmd_rise,
  input  logic       gate_en,
  input  logic       ilim,
  input  logic       fast_trip,
  input  logic [1:0] mode,
  input  logic       retry_clean,
  output logic       fault
);
  localparam int DG_W = cnt_width(umax(DEG_RUN, DEG_EDGE));
  localparam int HD_W = cnt_width(FAULT_HOLD);

  logic            edge_start;
  logic            qual, quiet_on;
  logic            deg_hit, hold_hit;
  logic [DG_W-1:0] deg_len;
  logic            set_ev, clr_ev;

  assign qual     = ilim && gate_en && cmd_on;
  assign quiet_on = !ilim && gate_en && cmd_on;
  assign deg_len  = edge_start ? DG_W'(DEG_EDGE) : DG_W'(DEG_RUN);

  ocp_tick_counter #(.W(DG_W)) u_deglitch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!qual),
    .adv    (tick && qual),
    .target (deg_len),
    .hit    (deg_hit)
  );

  ocp_tick_counter #(.W(HD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cmd_on || !fault),
    .adv    (tick && !cmd_on && fault),
    .target (HD_W'(FAULT_HOLD)),
    .hit    (hold_hit)
  );

  assign set_ev = deg_hit || (fast_trip && gate_en && cmd_on);
  assign clr_ev = hold_hit
               || (pol_hold(mode) && quiet_on)
               || (pol_retry(mode) && retry_clean);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault      <= 1'b0;
      edge_start <= 1'b0;
    end else begin
      if (set_ev)      fault <= 1'b1;
      else if (clr_ev) fault <= 1'b0;
      if (cmd_rise)      edge_start <= 1'b1;
      else if (quiet_on) edge_start <= 1'b0;
    end
  end

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(ilim || fast_trip));

  p_no_set_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_on && !fault) |=> !fault);

  p_latch_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_latch(mode) && fault && cmd_on) |=> fault);

endmodule

// File: rtl/ocp_mode_ctrl.sv
module ocp_mode_ctrl
  import ocp_pkg::*;
#(
  parameter int unsigned DEG_RUN     = 130,
  parameter int unsigned DEG_EDGE    = 400,
  parameter int unsigned LATCH_FIXED = 400,
  parameter int unsigned RETRY_ON    = 40000,
  parameter int unsigned RETRY_OFF   = 1000000,
  parameter int unsigned FAULT_HOLD  = 8500,
  parameter int unsigned DLY_W       = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             cmd_on,
  input  logic             ilim_act,
  input  logic             fast_trip,
  input  logic             therm_sd,
  input  logic [1:0]       mode_sel,
  input  logic [DLY_W-1:0] latch_extra,
  output logic             gate_en,
  output logic             oc_fault
);
  logic cmd_q;
  logic cmd_rise;
  logic retry_clean;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= 1'b0;
    else        cmd_q <= cmd_on;
  end

  assign cmd_rise = cmd_on && !cmd_q;

  ocp_policy_fsm #(
    .LATCH_FIXED (LATCH_FIXED),
    .RETRY_ON    (RETRY_ON),
    .RETRY_OFF   (RETRY_OFF),
    .DLY_W       (DLY_W)
  ) u_policy (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_us),
    .cmd_on      (cmd_on),
    .ilim        (ilim_act),
    .fast_trip   (fast_trip),
    .therm       (therm_sd),
    .mode        (mode_sel),
    .extra       (latch_extra),
    .gate_en     (gate_en),
    .retry_clean (retry_clean)
  );

  ocp_fault_flag #(
    .DEG_RUN    (DEG_RUN),
    .DEG_EDGE   (DEG_EDGE),
    .FAULT_HOLD (FAULT_HOLD)
  ) u_fault (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_us),
    .cmd_on      (cmd_on),
    .cmd_rise    (cmd_rise),
    .gate_en     (gate_en),
    .ilim        (ilim_act),
    .fast_trip   (fast_trip),
    .mode        (mode_sel),
    .retry_clean (retry_clean),
    .fault       (oc_fault)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!gate_en && !oc_fault));

endmodule

// File: tb/tb_ocp_mode_ctrl.sv
module tb_ocp_mode_ctrl;
  localparam int unsigned DR = 8, DE = 20, LF = 30, WON = 40, WOFF = 60, FH = 25, DW = 6;

  logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b1, cmd = 1'b0;
  logic          ilim = 1'b0, ftrip = 1'b0, therm = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [DW-1:0] extra = '0;
  wire           gate, fault;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ocp_mode_ctrl #(
    .DEG_RUN(DR), .DEG_EDGE(DE), .LATCH_FIXED(LF), .RETRY_ON(WON),
    .RETRY_OFF(WOFF), .FAULT_HOLD(FH), .DLY_W(DW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .cmd_on(cmd), .ilim_act(ilim),
    .fast_trip(ftrip), .therm_sd(therm), .mode_sel(mode), .latch_extra(extra),
    .gate_en(gate), .oc_fault(fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_fault(input int ticks_seen, input int window);
    return (ticks_seen >= window) ? 1 : 0;
  endfunction

  function automatic int latch_delay(input int e);
    return LF + e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int n;
    seed_dummy = $urandom(32'h0C0FFEE5);
    cyc(3);
    chk("R1 gate in reset", gate, 0);
    chk("R1 fault in reset", fault, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 gate after reset", gate, 0);
    chk("R1 fault after reset", fault, 0);

    // R2 basic on/off in hold policy
    cmd = 1'b1; cyc(1);
    chk("R2 gate on", gate, 1);
    cmd = 1'b0; cyc(1);
    chk("R2 gate off", gate, 0);
    cmd = 1'b1; cyc(2);

    // R7 / R11 / R3 directed deglitch in hold policy
    ilim = 1'b1; cyc(DR - 1);
    chk("R7 below window", fault, 0);
    chk("R3 hold conducts", gate, 1);
    cyc(1);
    chk("R7 at window", fault, 1);
    ilim = 1'b0; cyc(1);
    chk("R11 clear on quiet", fault, 0);
    chk("R3 gate after limit", gate, 1);

    // R3 thermal
    ilim = 1'b1; cyc(1);
    therm = 1'b1; cyc(1);
    chk("R3 thermal off", gate, 0);
    therm = 1'b0; cyc(1);
    chk("R3 thermal release", gate, 1);
    ilim = 1'b0; cyc(1);
    chk("R7 broken run no fault", fault, 0);

    // R7 / R11 random pulses with random tick density
    for (int it = 0; it < 24; it++) begin
      int len, pct, tsum;
      len  = 1 + int'($urandom % 16);
      pct  = 30 + int'($urandom % 70);
      tsum = 0;
      for (int k = 0; k < len; k++) begin
        tick = ((int'($urandom % 100)) < pct);
        ilim = 1'b1;
        tsum += int'(tick);
        cyc(1);
      end
      chk("R7 random pulse", fault, exp_fault(tsum, DR));
      ilim = 1'b0;
      tick = 1'(($urandom % 2));
      cyc(1);
      chk("R11 random clear", fault, 0);
    end
    tick = 1'b1;

    // R8 limiting present from the rising edge
    cmd = 1'b0; cyc(FH + 2);
    ilim = 1'b1; cmd = 1'b1; cyc(DE);
    chk("R8 edge window not done", fault, 0);
    cyc(1);
    chk("R8 edge window done", fault, 1);
    ilim = 1'b0; cyc(1);
    chk("R11 clear after edge", fault, 0);

    // R4 / R5 / R12 latch-off policy
    mode  = 2'b01;
    extra = DW'($urandom % 16);
    n     = latch_delay(int'(extra));
    cmd = 1'b0; cyc(2);
    cmd = 1'b1; cyc(2);
    ilim = 1'b1; cyc(n - 2);
    chk("R4 still on before delay", gate, 1);
    ilim = 1'b0; cyc(1);
    chk("R12 fault kept after limit ends", fault, 1);
    chk("R4 early stop keeps gate", gate, 1);
    ilim = 1'b1; cyc(n);
    chk("R4 restarted delay on", gate, 1);
    cyc(1);
    chk("R4 latched off", gate, 0);
    ilim = 1'b0; cyc(5);
    chk("R5 stays off", gate, 0);
    chk("R12 fault kept", fault, 1);

    // R10 hold timer restart, R5 recovery by toggle
    cmd = 1'b0; cyc(10);
    chk("R2 cmd low gate", gate, 0);
    chk("R10 short low keeps fault", fault, 1);
    cmd = 1'b1; cyc(1);
    chk("R5 recover after toggle", gate, 1);
    chk("R10 fault after early return", fault, 1);
    cmd = 1'b0; cyc(FH - 1);
    chk("R10 hold not expired", fault, 1);
    cyc(1);
    chk("R10 hold expired", fault, 0);

    // R6 auto-retry cadence
    mode = 2'b10;
    cmd = 1'b1; cyc(2);
    ilim = 1'b1; cyc(WON);
    chk("R6 on window", gate, 1);
    cyc(1);
    chk("R6 off window starts", gate, 0);
    chk("R7 fault in retry", fault, 1);
    cyc(WOFF - 1);
    chk("R6 off window end", gate, 0);
    cyc(1);
    chk("R6 retry on again", gate, 1);
    ilim = 1'b0; cyc(WON - 1);
    chk("R6 fault before clean window ends", fault, 1);
    cyc(1);
    chk("R6 clean window clears", fault, 0);
    chk("R6 stays on after clean", gate, 1);

    // R2 abort of a retry off-window
    ilim = 1'b1; cyc(WON + 1);
    chk("R6 second off window", gate, 0);
    cmd = 1'b0; ilim = 1'b0; cyc(1);
    chk("R2 low during off window", gate, 0);
    cmd = 1'b1; cyc(1);
    chk("R2 abort skips off window", gate, 1);

    // R9 fast trip in retry policy
    cmd = 1'b0; cyc(FH);
    chk("R10 cleared before trip", fault, 0);
    cmd = 1'b1; cyc(2);
    ftrip = 1'b1; cyc(1);
    ftrip = 1'b0;
    chk("R9 trip gate off", gate, 0);
    chk("R9 trip sets fault", fault, 1);
    cyc(WOFF - 1);
    chk("R9 retry off window", gate, 0);
    cyc(1);
    chk("R9 retry resumes", gate, 1);
    cyc(WON - 1);
    chk("R6 fault until clean end", fault, 1);
    cyc(1);
    chk("R6 clean after trip", fault, 0);

    // R9 fast trip in hold policy latches
    mode = 2'b00;
    ftrip = 1'b1; cyc(1);
    ftrip = 1'b0;
    chk("R9 hold trip off", gate, 0);
    cyc(5);
    chk("R9 hold trip latched", gate, 0);

    // R3 alternate hold code
    mode = 2'b11;
    cmd = 1'b0; cyc(2);
    cmd = 1'b1; cyc(2);
    ilim = 1'b1; cyc(LF + 20);
    chk("R3 code 11 holds", gate, 1);
    ilim = 1'b0; cyc(1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule